// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a classic serial controller presents to its host. Four pending flags record line-status errors, received data, an empty transmit holding register and modem-status changes. The serial engine raises each flag with a one-cycle set strobe. A four-bit enable mask selects which flags may take part. The highest-priority active source is encoded into the identification byte. The block drives the host interrupt line only when the auxiliary output enable from the modem control register is set, or when a board strap forces the line on.

The register interface passes in one-cycle read strobes. Reading the data register, the line-status register or the modem-status register clears the matching flag. Reading the identification byte clears the transmit-empty flag, but only when that byte reports transmit-empty. A mode input selects the interrupt line's form. In the oldest mode the line gives a single-cycle pulse each time an interrupt is raised. In the later modes it is a level that stays high while an interrupt is pending. In the FIFO-capable mode, the top two bits of the identification byte show whether the FIFOs are enabled.

Top module: `uart_irq_id`

## Requirements
- R1: A write to the enable register keeps only bits 3:0 (bit0 received data, bit1 transmit empty, bit2 line status, bit3 modem status). The stored value reads back on `ier_q`, and bits 7:4 of the write have no effect.
- R2: Only flags that are both pending and enabled compete. The order, highest first, is line status, received data, transmit empty, modem status.
- R3: `iid` bits 3:0 read 0x1 when no flag is pending and enabled. Otherwise they read 0x6 for line status, 0x4 for received data, 0x2 for transmit empty and 0x0 for modem status. Bits 5:4 are always 0.
- R4: `irq` stays low unless `out2` or `force_irq` is high.
- R5: With `mode` = 00, `irq` is high for exactly one cycle when the gated interrupt condition goes from inactive to active.
- R6: With `mode` = 01, 10 or 11, `irq` is high in every cycle in which some enabled flag is pending and the output is gated on.
- R7: A cycle with `rd_iid` high while `iid` bits 3:0 read 0x2 clears the transmit-empty flag. An `rd_iid` at any other code leaves that flag pending.
- R8: `rd_lsr` clears the line-status flag, and `rd_msr` clears the modem-status flag.
- R9: `rd_data` clears the received-data flag.
- R10: With `mode[1]` = 1 and `fifo_en` = 1, `iid` bits 7:6 read 11. In every other case they read 00.
- R11: After reset all flags and the enable register are zero, `iid` reads 0x01 and `irq` is low.
- R12: When a set strobe and the clearing read for the same flag fall in the same cycle, the flag is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_line | input | 1 | Raise line-status flag |
| set_rx | input | 1 | Raise received-data flag |
| set_tx | input | 1 | Raise transmit-empty flag |
| set_modem | input | 1 | Raise modem-status flag |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| out2 | input | 1 | Auxiliary output enable gating the line |
| force_irq | input | 1 | Strap forcing the line gate on |
| mode | input | 2 | 00 pulse style, 01 level, 1x level with FIFO bits |
| fifo_en | input | 1 | FIFO enable bit from the FIFO control register |
| rd_iid | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| rd_data | input | 1 | Data register read strobe (divisor access off) |
| ier_q | output | 4 | Stored enable register |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Host interrupt line |

## Verification
The block has no parameters, so the bench builds it as it stands and reaches every variant through the `mode`, `fifo_en`, `out2` and `force_irq` inputs. Switching these at run time exercises the pulse and level styles and the FIFO bits. It also covers the strap path alongside the modem-control gate. The enable mask is varied so that lower-priority sources surface as higher ones are masked or cleared. Reads of the identification byte are issued both while it shows transmit-empty and while it shows a higher code. Set strobes are also made to collide with clearing reads.

// File: rtl/uart_irq_id.sv
module uart_irq_id (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_line,
  input  logic       set_rx,
  input  logic       set_tx,
  input  logic       set_modem,
  input  logic       ier_we,
  input  logic [7:0] ier_wdata,
  input  logic       out2,
  input  logic       force_irq,
  input  logic [1:0] mode,
  input  logic       fifo_en,
  input  logic       rd_iid,
  input  logic       rd_lsr,
  input  logic       rd_msr,
  input  logic       rd_data,
  output logic [3:0] ier_q,
  output logic [7:0] iid,
  output logic       irq
);
  // flag order matches enable bits: 0 rx, 1 tx, 2 line, 3 modem
  logic [3:0] pend, hit, set_v, clr_v;
  logic [2:0] code;
  logic       any, gated, act_q;

  assign hit = pend & ier_q;
  assign any = |hit;

  always_comb begin
    if (hit[2])      code = 3'b011;
    else if (hit[0]) code = 3'b010;
    else if (hit[1]) code = 3'b001;
    else             code = 3'b000;
  end

  assign iid   = {{2{mode[1] & fifo_en}}, 2'b00, code, ~any};
  assign set_v = {set_modem, set_line, set_tx, set_rx};
  assign clr_v = {rd_msr, rd_lsr, rd_iid & any & (code == 3'b001), rd_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      ier_q <= '0;
      act_q <= 1'b0;
    end else begin
      pend  <= (pend & ~clr_v) | set_v;
      act_q <= gated;
      if (ier_we) ier_q <= ier_wdata[3:0];
    end
  end

  assign gated = any & (out2 | force_irq);
  assign irq   = (mode == 2'b00) ? (gated & ~act_q) : gated;
endmodule

module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_line,
  input logic       set_tx,
  input logic       ier_we,
  input logic [7:0] ier_wdata,
  input logic       out2,
  input logic       force_irq,
  input logic [1:0] mode,
  input logic       rd_iid,
  input logic       rd_lsr,
  input logic [3:0] ier_q,
  input logic [7:0] iid,
  input logic       irq
);
  // R1
  ier_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_we |=> ({4'b0, ier_q} == ($past(ier_wdata) & 8'h0F)));
  // R3
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iid[0] |-> (iid[5:1] == 5'b0));
  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out2 || force_irq) |-> !irq);
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && irq) |=> (mode != 2'b00 || !irq));
  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && (out2 || force_irq) && !iid[0]) |-> irq);
  // R7
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iid && iid[3:0] == 4'h2 && !set_tx) |=> (iid[3:0] != 4'h2));
  // R8
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !set_line) |=> (iid[3:0] != 4'h6));
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (.*);

// File: tb/uart_irq_id_bench.sv
module uart_irq_id_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic set_line = 0, set_rx = 0, set_tx = 0, set_modem = 0;
  logic ier_we = 0;
  logic [7:0] ier_wdata = 0;
  logic out2 = 0, force_irq = 0, fifo_en = 0;
  logic [1:0] mode = 2'b01;
  logic rd_iid = 0, rd_lsr = 0, rd_msr = 0, rd_data = 0;
  logic [3:0] ier_q;
  logic [7:0] iid;
  logic irq;

  int checks = 0, errors = 0;
  bit run = 0;
  string cur_req = "R11";

  // reference state
  bit m_line, m_rx, m_tx, m_mod, m_prev;
  int m_ier;

  uart_irq_id u_uart_irq_id (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_low();
    if (m_line && m_ier[2]) return 6;
    if (m_rx && m_ier[0]) return 4;
    if (m_tx && m_ier[1]) return 2;
    if (m_mod && m_ier[3]) return 0;
    return 1;
  endfunction

  function automatic bit exp_gated();
    return (exp_low() != 1) && (out2 || force_irq);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line <= 0; m_rx <= 0; m_tx <= 0; m_mod <= 0; m_prev <= 0; m_ier <= 0;
    end else begin
      m_prev <= exp_gated();
      m_line <= set_line  || (m_line && !rd_lsr);
      m_mod  <= set_modem || (m_mod && !rd_msr);
      m_rx   <= set_rx    || (m_rx && !rd_data);
      m_tx   <= set_tx    || (m_tx && !(rd_iid && exp_low() == 2));
      if (ier_we) m_ier <= ier_wdata % 16;
    end
  end

  always @(negedge clk) begin
    if (run && rst_n) begin
      int e_iid;
      bit e_irq;
      e_iid = exp_low() + ((mode[1] && fifo_en) ? 8'hC0 : 0);
      e_irq = (mode == 2'b00) ? (exp_gated() && !m_prev) : exp_gated();
      checks++;
      if (iid != e_iid[7:0] || irq != e_irq || int'(ier_q) != m_ier) begin
        errors++;
        $display("FAIL %s: iid=%02h irq=%0b ier=%0h expected iid=%02h irq=%0b ier=%0h",
                 cur_req, iid, irq, ier_q, e_iid[7:0], e_irq, m_ier[3:0]);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, bit cond, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_we = 1; ier_wdata = v; tick(); ier_we = 0;
  endtask

  task automatic set_all();
    set_line = 1; set_rx = 1; set_tx = 1; set_modem = 1; tick();
    set_line = 0; set_rx = 0; set_tx = 0; set_modem = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    // R11
    chk("R11", iid == 8'h01 && irq == 0 && ier_q == 0, iid, 8'h01);
    run = 1;

    cur_req = "R1";
    wr_ier(8'hFF);
    chk("R1", ier_q == 4'hF, ier_q, 4'hF);
    wr_ier(8'hA5);
    chk("R1", ier_q == 4'h5, ier_q, 4'h5);
    wr_ier(8'h0F);

    cur_req = "R2"; out2 = 1;
    set_all(); tick();
    chk("R3", iid == 8'h06, iid, 8'h06);
    cur_req = "R7"; rd_iid = 1; tick(); rd_iid = 0;
    chk("R7", iid == 8'h06, iid, 8'h06);
    cur_req = "R8"; rd_lsr = 1; tick(); rd_lsr = 0;
    chk("R2", iid == 8'h04, iid, 8'h04);
    cur_req = "R9"; rd_data = 1; tick(); rd_data = 0;
    chk("R9", iid == 8'h02, iid, 8'h02);
    cur_req = "R7"; rd_iid = 1; tick(); rd_iid = 0;
    chk("R7", iid == 8'h00, iid, 8'h00);
    cur_req = "R8"; rd_msr = 1; tick(); rd_msr = 0;
    chk("R8", iid == 8'h01 && irq == 0, iid, 8'h01);

    cur_req = "R2";
    wr_ier(8'h08); set_all(); tick();
    chk("R2", iid == 8'h00, iid, 8'h00);
    wr_ier(8'h02); tick();
    chk("R2", iid == 8'h02, iid, 8'h02);
    wr_ier(8'h00); tick();
    chk("R3", iid == 8'h01, iid, 8'h01);

    cur_req = "R4"; wr_ier(8'h0F); out2 = 0; tick();
    chk("R4", irq == 0, irq, 0);
    force_irq = 1; tick();
    chk("R4", irq == 1, irq, 1);
    force_irq = 0; out2 = 1; tick();
    chk("R6", irq == 1, irq, 1);

    cur_req = "R5"; rd_lsr = 1; rd_msr = 1; rd_data = 1; tick();
    rd_lsr = 0; rd_msr = 0; rd_data = 0;
    rd_iid = 1; tick(); rd_iid = 0;
    mode = 2'b00; tick(); tick();
    set_rx = 1; tick(); set_rx = 0;
    chk("R5", irq == 1, irq, 1);
    tick();
    chk("R5", irq == 0, irq, 0);
    set_line = 1; tick(); set_line = 0; tick();
    chk("R5", irq == 0, irq, 0);

    cur_req = "R6"; mode = 2'b01; tick();
    chk("R6", irq == 1, irq, 1);

    cur_req = "R10"; fifo_en = 1; tick();
    chk("R10", iid[7:6] == 2'b00, iid, 0);
    mode = 2'b10; tick();
    chk("R10", iid[7:6] == 2'b11, iid, 8'hC6);
    fifo_en = 0; tick();
    chk("R10", iid[7:6] == 2'b00, iid, 0);

    cur_req = "R12"; rd_lsr = 1; set_line = 1; rd_data = 1; tick();
    rd_lsr = 0; set_line = 0; rd_data = 0;
    chk("R12", iid[3:0] == 4'h6, iid, 6);
    rd_lsr = 1; tick(); rd_lsr = 0;
    set_rx = 1; rd_data = 1; tick(); set_rx = 0; rd_data = 0;
    chk("R12", iid[3:0] == 4'h4, iid, 4);
    rd_data = 1; tick(); rd_data = 0;
    chk("R9", iid[3:0] == 4'h1, iid, 1);

    cur_req = "R11"; rst_n = 0; tick(); rst_n = 1; tick();
    chk("R11", iid == 8'h01 && irq == 0 && ier_q == 0, iid, 8'h01);

    run = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule